// File: doc/BRIEF.md
# Burst Address Counter

This block supplies the address that one port of a synchronous memory uses in each clock cycle. The memory controller presents an external address and three active-low controls: clear, strobe and advance. The block decides among four actions in fixed priority. Clear gives address zero. Strobe takes the external address. Advance steps the held address up by one. With none of these asserted, the held address is used again.

The chosen address appears on `addr_used_o` within the same cycle, so the memory array can act on it at the next rising edge. That edge also stores the address in an internal register. A registered copy of it is exposed on `addr_held_o`, which the next cycle uses as its base. Chip selects and byte selects have no path into the block. Burst sequencing therefore continues whether or not the port is selected.

Top module: `burst_addr_counter`

## Requirements
- R1: While `cntrst_ni` is 0, `addr_used_o` is 0 for every value of `ads_ni`, `cnten_ni` and `addr_i`.
- R2: While `cntrst_ni` is 1 and `ads_ni` is 0, `addr_used_o` equals `addr_i`, whatever the value of `cnten_ni`. After the edge, `addr_held_o` equals that loaded address and not its successor.
- R3: While `cntrst_ni`, `ads_ni` and `cnten_ni` are all 1, `addr_used_o` equals `addr_held_o`, and the held value does not change across the edge.
- R4: While `cntrst_ni` and `ads_ni` are 1 and `cnten_ni` is 0, `addr_used_o` equals `addr_held_o` plus one.
- R5: Advancing from the all-ones address (0x7FFF at the default 15-bit width) gives address 0.
- R6: After each rising edge of `clk_i`, `addr_held_o` equals the value that `addr_used_o` had just before that edge.
- R7: While `rst_ni` is 0, `addr_held_o` is 0 at once, without waiting for a clock edge. After release with all controls at 1, `addr_used_o` is 0.
- R8: A clear cycle is a usable cycle: it presents address 0 itself. An advance in the very next cycle presents address 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the held address |
| addr_i | input | ADDR_W (15) | External address |
| ads_ni | input | 1 | Active-low strobe: use and load `addr_i` |
| cnten_ni | input | 1 | Active-low advance of the held address |
| cntrst_ni | input | 1 | Active-low clear to address 0 |
| addr_used_o | output | ADDR_W (15) | Address used in the current cycle |
| addr_held_o | output | ADDR_W (15) | Registered address from the previous edge |

## Verification
Clear and strobe can be asserted in the same cycle, and so can strobe and advance. The bench drives such pairs with distinct external addresses: clear with strobe and advance both low, and strobe with advance low. In each case it checks that only the higher-priority action shows on `addr_used_o`. It then lets one edge pass and confirms through `addr_held_o` that the losing action left no trace in the held address. A case where the address is 0x1234 and the result stays 0x1234 rather than 0x1235 proves that the advance was discarded.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  typedef enum logic [1:0] {
    SEL_CLEAR = 2'd0,
    SEL_LOAD  = 2'd1,
    SEL_STEP  = 2'd2,
    SEL_KEEP  = 2'd3
  } addr_sel_e;

endpackage

// File: rtl/burst_ctrl_decode.sv
module burst_ctrl_decode
  import burst_addr_pkg::*;
(
  input  logic      ads_ni,
  input  logic      cnten_ni,
  input  logic      cntrst_ni,
  output addr_sel_e sel_o
);

  // priority: clear > load > step > keep
  always_comb begin
    if (!cntrst_ni)    sel_o = SEL_CLEAR;
    else if (!ads_ni)  sel_o = SEL_LOAD;
    else if (!cnten_ni) sel_o = SEL_STEP;
    else               sel_o = SEL_KEEP;
  end

  always_comb begin
    assert (sel_o == SEL_CLEAR || cntrst_ni)
      else $error("p_clear_wins_r1");
  end

endmodule

// File: rtl/burst_addr_mux.sv
module burst_addr_mux
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  addr_sel_e          sel_i,
  input  logic [ADDR_W-1:0]  ext_addr_i,
  input  logic [ADDR_W-1:0]  held_addr_i,
  output logic [ADDR_W-1:0]  addr_o
);

  logic [ADDR_W-1:0] step_addr;

  // natural modulo wrap at the top of the space
  assign step_addr = held_addr_i + ADDR_W'(1);

  always_comb begin
    unique case (sel_i)
      SEL_CLEAR: addr_o = '0;
      SEL_LOAD:  addr_o = ext_addr_i;
      SEL_STEP:  addr_o = step_addr;
      default:   addr_o = held_addr_i;
    endcase
  end

endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg #(
  parameter int ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] d_i,
  output logic [ADDR_W-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end

  p_held_follows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> q_o == $past(d_i))
    else $error("p_held_follows_r6");

endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ads_ni,
  input  logic              cnten_ni,
  input  logic              cntrst_ni,
  output logic [ADDR_W-1:0] addr_used_o,
  output logic [ADDR_W-1:0] addr_held_o
);

  localparam logic [ADDR_W-1:0] ADDR_TOP = {ADDR_W{1'b1}};

  addr_sel_e         sel;
  logic [ADDR_W-1:0] held_q;

  burst_ctrl_decode i_decode (
    .ads_ni    (ads_ni),
    .cnten_ni  (cnten_ni),
    .cntrst_ni (cntrst_ni),
    .sel_o     (sel)
  );

  burst_addr_mux #(.ADDR_W(ADDR_W)) i_mux (
    .sel_i       (sel),
    .ext_addr_i  (addr_i),
    .held_addr_i (held_q),
    .addr_o      (addr_used_o)
  );

  burst_addr_reg #(.ADDR_W(ADDR_W)) i_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (addr_used_o),
    .q_o    (held_q)
  );

  assign addr_held_o = held_q;

  p_clear_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cntrst_ni |-> addr_used_o == '0)
    else $error("p_clear_zero_r1");

  p_load_ext_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cntrst_ni && !ads_ni) |=> addr_held_o == $past(addr_i))
    else $error("p_load_ext_r2");

  p_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cntrst_ni && ads_ni && cnten_ni) |=> $stable(addr_held_o))
    else $error("p_keep_r3");

  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cntrst_ni && ads_ni && !cnten_ni) |-> addr_used_o == addr_held_o + ADDR_W'(1))
    else $error("p_step_r4");

  p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cntrst_ni && ads_ni && !cnten_ni && addr_held_o == ADDR_TOP) |=> addr_held_o == '0)
    else $error("p_wrap_r5");

endmodule

// File: tb/test_burst_addr_counter.sv
module test_burst_addr_counter;

  localparam int AW = 15;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          ads_ni = 1'b1;
  logic          cnten_ni = 1'b1;
  logic          cntrst_ni = 1'b1;
  logic [AW-1:0] addr_used_o;
  logic [AW-1:0] addr_held_o;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] model = '0;

  always #2.5 clk_i = ~clk_i;

  burst_addr_counter #(.ADDR_W(AW)) i_burst_addr_counter (
    .clk_i, .rst_ni, .addr_i, .ads_ni, .cnten_ni, .cntrst_ni,
    .addr_used_o, .addr_held_o
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive controls mid-cycle, check used address, clock, check held copy
  task automatic step(input logic rst, input logic ads, input logic en,
                      input logic [AW-1:0] a, input string req);
    logic [AW-1:0] exp;
    @(negedge clk_i);
    cntrst_ni = rst; ads_ni = ads; cnten_ni = en; addr_i = a;
    if (!rst)      exp = '0;
    else if (!ads) exp = a;
    else if (!en)  exp = model + 1'b1;
    else           exp = model;
    #1 chk(req, addr_used_o, exp);
    @(posedge clk_i); #1;
    model = exp;
    chk({req, "/R6"}, addr_held_o, exp);
  endtask

  task automatic t_reset_state();
    chk("R7", addr_held_o, '0);
    @(negedge clk_i); rst_ni = 1'b1;
    step(1, 1, 1, 15'h2AAA, "R7");
  endtask

  task automatic t_load();
    step(1, 0, 1, 15'h0123, "R2");
    step(1, 0, 0, 15'h1234, "R2");
    step(1, 1, 1, 15'h5555, "R3");
    chk("R2", addr_held_o, 15'h1234);
  endtask

  task automatic t_advance();
    step(1, 0, 1, 15'h0100, "R2");
    for (int k = 0; k < 4; k++) step(1, 1, 0, 15'h7000, "R4");
    chk("R4", addr_held_o, 15'h0104);
    step(1, 1, 1, 15'h0000, "R3");
    step(1, 1, 1, 15'h7FFF, "R3");
  endtask

  task automatic t_clear();
    step(1, 0, 1, 15'h3333, "R2");
    step(0, 0, 0, 15'h4444, "R1");
    step(1, 0, 1, 15'h3333, "R2");
    step(0, 1, 0, 15'h4444, "R1");
    step(0, 1, 1, 15'h4444, "R1");
  endtask

  task automatic t_wrap();
    step(1, 0, 1, 15'h7FFE, "R2");
    step(1, 1, 0, 15'h0000, "R4");
    step(1, 1, 0, 15'h0000, "R5");
    chk("R5", addr_held_o, 15'h0000);
    step(1, 1, 0, 15'h0000, "R5");
  endtask

  task automatic t_clear_then_step();
    step(1, 0, 1, 15'h0ABC, "R2");
    step(0, 1, 0, 15'h0ABC, "R8");
    step(1, 1, 0, 15'h0ABC, "R8");
    chk("R8", addr_held_o, 15'h0001);
  endtask

  task automatic t_async_reset();
    step(1, 0, 1, 15'h6789, "R2");
    @(negedge clk_i); cntrst_ni = 1; ads_ni = 1; cnten_ni = 1;
    #1 rst_ni = 1'b0;
    #0.5 chk("R7", addr_held_o, '0);
    @(negedge clk_i); rst_ni = 1'b1;
    model = '0;
    step(1, 1, 1, 15'h1111, "R7");
  endtask

  initial begin
    fork
      begin
        #1;
        t_reset_state();
        t_load();
        t_advance();
        t_clear();
        t_wrap();
        t_clear_then_step();
        t_async_reset();
      end
      begin
        repeat (5000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule